// File: doc/BRIEF.md
# Audio Sample Level Violation Monitor

This block watches audio samples in two's-complement form as they arrive in numbered time slots. For each valid sample it takes only the upper byte and strips the sign to get a magnitude. It then tests that magnitude against a 7-bit ceiling that software programs. A sample whose magnitude is above the ceiling sets a sticky flag for its slot. The flags live in a 32-bit report word. Slots 0 to 15 come from the first slot list and slots 16 to 31 from the second.

Software reads the report word with a one-cycle read strobe. The read returns the current flags and clears the whole word. A violation that arrives in the same cycle as the read is kept in the freshly cleared word, so no event is lost. Comparison runs on every valid sample, and there is no enable.

Top module: `lvlmon_top`

## Requirements
- R1: After synchronous reset, the report word `rpt_q` is all zeros.
- R2: A sample with `smp_vld` high sets bit `smp_slot` of the report word one cycle later when the magnitude of `smp_msb` (read as a signed 8-bit value) is strictly greater than `lvl_max`.
- R3: A sample whose magnitude is less than or equal to `lvl_max` leaves the report word unchanged. This includes a magnitude exactly equal to the ceiling and a ceiling of 127 with a byte of -127.
- R4: The byte value 0x80 (-128) counts as magnitude 128 and always sets its slot bit, even when `lvl_max` is 127.
- R5: A set bit stays set until a read, whatever later samples in that slot show.
- R6: When `rd_stb` is high, `rd_data` shows the report word as it stood before that edge. On the next cycle every bit is zero, apart from any violation that arrived in the same cycle as the read.
- R7: A sample whose `smp_vld` is low has no effect on the report word.
- R8: Each sample changes only the bit indexed by `smp_slot`, for every slot from 0 to 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample valid strobe |
| smp_msb | input | 8 | Upper byte of the sample, two's complement |
| smp_slot | input | 5 | Time-slot index of the sample |
| lvl_max | input | 7 | Programmable ceiling, 0 to 127 |
| rd_stb | input | 1 | Read strobe; clears the report word |
| rd_data | output | 32 | Report word returned for a read (combinational) |
| rpt_q | output | 32 | Live report word |

## Verification
The assertions assume that every input is a known value while reset is low. They also assume that `lvl_max` stays steady across the cycle in which a sample is judged, because the ceiling is a quasi-static setting. The bench changes `lvl_max` only in cycles where no valid sample is driven, and it drives all inputs on the falling edge. Read strobes last a single cycle, and some are placed deliberately on the same cycle as a violating sample to exercise the no-loss rule.

// File: rtl/lvlmon_pkg.sv
package lvlmon_pkg;
    localparam int SLOTS     = 32;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int BYTE_W    = 8;
    localparam int LVL_W     = BYTE_W - 1;
    localparam int LIST_SIZE = SLOTS / 2;

    typedef logic [SLOTS-1:0] rpt_t;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] msb;
        logic [SLOT_W-1:0] slot;
    } smp_t;

    // Magnitude of a signed byte; 9 bits hold the -128 case.
    function automatic logic [BYTE_W:0] mag_of(input logic [BYTE_W-1:0] b);
        logic [BYTE_W:0] ext;
        ext = {b[BYTE_W-1], b};
        return b[BYTE_W-1] ? (~ext + 1'b1) : ext;
    endfunction
endpackage

// File: rtl/lvlmon_cmp.sv
module lvlmon_cmp
    import lvlmon_pkg::*;
(
    input  smp_t             smp,
    input  logic [LVL_W-1:0] lvl_max,
    output rpt_t             hit_vec
);
    logic [BYTE_W:0] mag;
    logic            over;

    always_comb begin
        mag  = mag_of(smp.msb);
        over = smp.vld && (mag > {2'b00, lvl_max});
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_dec
        assign hit_vec[i] = over && (smp.slot == SLOT_W'(i));
    end
endmodule

// File: rtl/lvlmon_reg.sv
module lvlmon_reg
    import lvlmon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rpt_t hit_vec,
    input  logic rd_stb,
    output rpt_t rpt_q
);
    rpt_t nxt;

    always_comb begin
        nxt = (rd_stb ? '0 : rpt_q) | hit_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) rpt_q <= '0;
        else     rpt_q <= nxt;
    end
endmodule

// File: rtl/lvlmon_top.sv
module lvlmon_top
    import lvlmon_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_vld,
    input  logic [7:0]  smp_msb,
    input  logic [4:0]  smp_slot,
    input  logic [6:0]  lvl_max,
    input  logic        rd_stb,
    output logic [31:0] rd_data,
    output logic [31:0] rpt_q
);
    smp_t smp;
    rpt_t hit_vec;
    rpt_t rpt_w;

    assign smp = '{vld: smp_vld, msb: smp_msb, slot: smp_slot};

    lvlmon_cmp u_cmp (
        .smp     (smp),
        .lvl_max (lvl_max),
        .hit_vec (hit_vec)
    );

    lvlmon_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .hit_vec (hit_vec),
        .rd_stb  (rd_stb),
        .rpt_q   (rpt_w)
    );

    assign rpt_q   = rpt_w;
    assign rd_data = rpt_w;
endmodule

// File: rtl/lvlmon_chk.sv
module lvlmon_chk (
    input logic        clk,
    input logic        rst,
    input logic        smp_vld,
    input logic [7:0]  smp_msb,
    input logic [4:0]  smp_slot,
    input logic [6:0]  lvl_max,
    input logic        rd_stb,
    input logic [31:0] rpt_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (rpt_q == '0));

    // R4
    neg_full_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && smp_msb == 8'h80) |=> rpt_q[$past(smp_slot)]);

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb && rpt_q[smp_slot]) |=> rpt_q[$past(smp_slot)]);

    // R7
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!smp_vld && !rd_stb) |=> $stable(rpt_q));

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !smp_vld) |=> (rpt_q == '0));

    // R8
    one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ($countones(rpt_q & ~$past(rpt_q)) <= 1));
endmodule

bind lvlmon_top lvlmon_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (smp_vld),
    .smp_msb  (smp_msb),
    .smp_slot (smp_slot),
    .lvl_max  (lvl_max),
    .rd_stb   (rd_stb),
    .rpt_q    (rpt_q)
);

// File: tb/lvlmon_tb.sv
module lvlmon_top_tb_top;
    logic        clk = 0;
    logic        rst;
    logic        smp_vld;
    logic [7:0]  smp_msb;
    logic [4:0]  smp_slot;
    logic [6:0]  lvl_max;
    logic        rd_stb;
    logic [31:0] rd_data;
    logic [31:0] rpt_q;

    int n_cmp = 0;
    int n_bad = 0;

    lvlmon_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .smp_vld  (smp_vld),
        .smp_msb  (smp_msb),
        .smp_slot (smp_slot),
        .lvl_max  (lvl_max),
        .rd_stb   (rd_stb),
        .rd_data  (rd_data),
        .rpt_q    (rpt_q)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        smp_vld = 0; rd_stb = 0; smp_msb = 0; smp_slot = 0;
    endtask

    // Drive one sample on the falling edge, then let it take effect at the next rising edge.
    task automatic send(input logic [4:0] s, input logic [7:0] b);
        @(negedge clk);
        smp_vld = 1; smp_slot = s; smp_msb = b; rd_stb = 0;
        @(negedge clk);
        idle();
    endtask

    task automatic do_read(input string req, input logic [31:0] exp);
        @(negedge clk);
        idle(); rd_stb = 1;
        #1 check(req, rd_data, exp);
        @(negedge clk);
        idle();
        check(req, rpt_q, 32'h0);
    endtask

    task automatic t_reset();
        rst = 1; idle(); lvl_max = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        check("R1", rpt_q, 32'h0);
    endtask

    task automatic t_compare();
        lvl_max = 7'd20;
        send(5'd3, 8'd21);   // 21 > 20
        check("R2", rpt_q, 32'h8);
        send(5'd4, 8'd20);   // equal: no violation
        check("R3", rpt_q, 32'h8);
        send(5'd5, 8'hEB);   // -21 -> 21
        check("R2", rpt_q, 32'h28);
        send(5'd6, 8'hEC);   // -20 -> equal
        check("R3", rpt_q, 32'h28);
        do_read("R6", 32'h28);
    endtask

    task automatic t_extremes();
        @(negedge clk); lvl_max = 7'd127;
        send(5'd17, 8'h81);  // -127
        check("R3", rpt_q, 32'h0);
        send(5'd18, 8'h7F);
        check("R3", rpt_q, 32'h0);
        send(5'd31, 8'h80);  // -128 always over
        check("R4", rpt_q, 32'h8000_0000);
        @(negedge clk); lvl_max = 7'd0;
        send(5'd0, 8'h00);
        check("R3", rpt_q, 32'h8000_0000);
        send(5'd16, 8'hFF);  // -1 > 0
        check("R2", rpt_q, 32'h8001_0000);
        do_read("R6", 32'h8001_0000);
    endtask

    task automatic t_sticky_idle();
        @(negedge clk); lvl_max = 7'd10;
        send(5'd9, 8'd50);
        send(5'd9, 8'd1);
        check("R5", rpt_q, 32'h200);
        @(negedge clk);
        smp_vld = 0; smp_slot = 5'd12; smp_msb = 8'h80;
        @(negedge clk);
        idle();
        check("R7", rpt_q, 32'h200);
        do_read("R6", 32'h200);
    endtask

    task automatic t_same_cycle();
        @(negedge clk); lvl_max = 7'd5;
        send(5'd1, 8'd9);
        @(negedge clk);
        smp_vld = 1; smp_slot = 5'd2; smp_msb = 8'd9; rd_stb = 1;
        #1 check("R6", rd_data, 32'h2);
        @(negedge clk);
        idle();
        check("R6", rpt_q, 32'h4);
        do_read("R6", 32'h4);
    endtask

    task automatic t_walk();
        logic [31:0] exp = 0;
        @(negedge clk); lvl_max = 7'd3;
        for (int i = 0; i < 32; i++) begin
            send(5'(i), 8'd4);
            exp[i] = 1'b1;
            check("R8", rpt_q, exp);
        end
        do_read("R8", 32'hFFFF_FFFF);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_compare();
                t_extremes();
                t_sticky_idle();
                t_same_cycle();
                t_walk();
            end
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule